// File: doc/BRIEF.md
# Programmable Clock Waveform Generator

This block builds a clock waveform out of a slower time-step signal. Every change of level on the time-step input, seen on the system clock, counts as one tick. Four programmable settings shape the waveform: how many ticks the output spends low, how many it spends high, the tick at which the first edge happens, and the level held before that edge. Until the first-edge tick the output sits at the programmed starting level. From that tick on it repeats a period of low-plus-high ticks. The phase is chosen so that the first edge rises when the output starts low and falls when it starts high.

The settings are written into a staging bank through a small write port. They go live only on a synchronous restart, which also clears the tick count and the remembered time-step level. A duration or first-edge value of all ones (2^W-1) stands for infinity, so the matching transition never happens. A separate validity input marks the time-step level as unknown. The output flag then reports the waveform as unknown, and no tick is taken.

The controller is a state machine with three states. ST_WAIT holds the starting level. ST_LOW and ST_HIGH are the two halves of the period, each timed by a dwell counter. Transitions:
- WAIT_TO_EDGE leaves ST_WAIT on the first-edge tick. It enters ST_HIGH when the output starts low and ST_LOW when it starts high.
- HIGH_DONE goes from ST_HIGH to ST_LOW after the high-duration ticks.
- LOW_DONE goes from ST_LOW to ST_HIGH after the low-duration ticks.
- SKIP_EMPTY enters the opposite state directly when the duration of the state being entered is zero.
- LOAD happens on reset or restart. It enters ST_WAIT, or the first-edge state at once when the first-edge value is zero.

Top module: `clkwave_gen`

## Requirements
- R1: A tick is a cycle with step_valid=1 and step_lvl different from the last accepted level. That level is cleared to 0 by rst and by restart. Any cycle without a tick leaves wave_out unchanged.
- R2: A cycle with step_valid=0 drives wave_known to 0 in the next cycle and takes no tick, even if step_lvl changes. The remembered level is not updated. step_valid=1 drives wave_known to 1.
- R3: While the tick count since the last load is below the first-edge value, wave_out equals the inverse of the start-low flag.
- R4: With start-low set, wave_out rises on the tick that reaches the first-edge value F. It then stays high for H ticks and low for L ticks, repeating.
- R5: With start-low clear, wave_out falls on tick F. It then stays low for L ticks and high for H ticks, repeating.
- R6: A value of 2^W-1 for H, L or F is infinite: the transition that value would time never occurs.
- R7: If exactly one of L and H is zero, the output stays at the other level from the first edge on. If F is zero, the post-edge level appears directly after the load.
- R8: A write with cfg_we=1 stores cfg_data into a staging bank selected by cfg_sel: 0 is L, 1 is H, 2 is F, 3 is the start-low flag in bit 0. Staged values have no effect on wave_out until a restart. rst loads the parameter defaults into both banks.
- R9: restart copies the staging bank into the live settings, including a write made in the same cycle. It clears the tick count and the remembered level. A tick offered in the restart cycle is dropped.
- R10: The tick and dwell counters saturate rather than wrap. With an infinite duration the output holds over more than 2^W ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, loads default settings |
| restart | input | 1 | Synchronous restart, makes staged settings live |
| cfg_we | input | 1 | Staging write enable |
| cfg_sel | input | 2 | Staging field select |
| cfg_data | input | W | Staging write data |
| step_lvl | input | 1 | Time-step level |
| step_valid | input | 1 | Time-step level is known |
| wave_out | output | 1 | Generated waveform |
| wave_known | output | 1 | Waveform is known this cycle |

## Verification
Two pairs of functions can fall in the same cycle. A restart can coincide with a time-step change, and a staging write can coincide with the restart that loads it. The bench provokes both: it toggles step_lvl and writes the first-edge value in the very restart cycle. Its reference model drops that tick and takes the fresh value. The waveform is then compared on every following clock, so a design that counts the tick or loads the stale value shows up as a shifted edge.

// File: rtl/clkwave_pkg.sv
package clkwave_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } wave_st_t;

    localparam logic [1:0] SEL_LOW   = 2'd0;
    localparam logic [1:0] SEL_HIGH  = 2'd1;
    localparam logic [1:0] SEL_FIRST = 2'd2;
    localparam logic [1:0] SEL_INIT  = 2'd3;

endpackage

// File: rtl/clkwave_cfg.sv
module clkwave_cfg
    import clkwave_pkg::*;
#(
    parameter int W            = 16,
    parameter int DEF_LOW      = 4,
    parameter int DEF_HIGH     = 4,
    parameter int DEF_FIRST    = 2,
    parameter int DEF_INIT_LOW = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         we,
    input  logic [1:0]   sel,
    input  logic [W-1:0] data,
    output logic [W-1:0] act_low,
    output logic [W-1:0] act_high,
    output logic [W-1:0] act_first,
    output logic         act_init_low,
    output logic [W-1:0] ld_low,
    output logic [W-1:0] ld_high,
    output logic [W-1:0] ld_first,
    output logic         ld_init_low
);

    localparam logic [W-1:0] D_LOW   = W'(DEF_LOW);
    localparam logic [W-1:0] D_HIGH  = W'(DEF_HIGH);
    localparam logic [W-1:0] D_FIRST = W'(DEF_FIRST);
    localparam logic         D_INIT  = (DEF_INIT_LOW != 0);

    logic [W-1:0] stg_low_q,   stg_low_n;
    logic [W-1:0] stg_high_q,  stg_high_n;
    logic [W-1:0] stg_first_q, stg_first_n;
    logic         stg_init_q,  stg_init_n;

    // staging bank with the current write folded in
    always_comb begin
        stg_low_n   = stg_low_q;
        stg_high_n  = stg_high_q;
        stg_first_n = stg_first_q;
        stg_init_n  = stg_init_q;
        if (we) begin
            unique case (sel)
                SEL_LOW:   stg_low_n   = data;
                SEL_HIGH:  stg_high_n  = data;
                SEL_FIRST: stg_first_n = data;
                SEL_INIT:  stg_init_n  = data[0];
                default:   stg_init_n  = stg_init_q;
            endcase
        end
    end

    // values that the live bank takes on at this edge when a load occurs
    always_comb begin
        ld_low      = rst ? D_LOW   : stg_low_n;
        ld_high     = rst ? D_HIGH  : stg_high_n;
        ld_first    = rst ? D_FIRST : stg_first_n;
        ld_init_low = rst ? D_INIT  : stg_init_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_low_q    <= D_LOW;
            stg_high_q   <= D_HIGH;
            stg_first_q  <= D_FIRST;
            stg_init_q   <= D_INIT;
            act_low      <= D_LOW;
            act_high     <= D_HIGH;
            act_first    <= D_FIRST;
            act_init_low <= D_INIT;
        end else begin
            stg_low_q   <= stg_low_n;
            stg_high_q  <= stg_high_n;
            stg_first_q <= stg_first_n;
            stg_init_q  <= stg_init_n;
            if (restart) begin
                act_low      <= stg_low_n;
                act_high     <= stg_high_n;
                act_first    <= stg_first_n;
                act_init_low <= stg_init_n;
            end
        end
    end

endmodule

// File: rtl/clkwave_tick.sv
module clkwave_tick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         lvl,
    input  logic         vld,
    output logic         tick,
    output logic         known,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt
);

    localparam logic [W-1:0] CMAX = '1;

    logic prev_q;

    always_comb begin
        tick    = vld && (lvl != prev_q) && !restart && !rst;
        cnt_nxt = (cnt == CMAX) ? CMAX : cnt + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            prev_q <= 1'b0;
            cnt    <= '0;
        end else if (tick) begin
            prev_q <= lvl;
            cnt    <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) known <= 1'b1;
        else     known <= vld;
    end

endmodule

// File: rtl/clkwave_fsm.sv
module clkwave_fsm
    import clkwave_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] act_low,
    input  logic [W-1:0] act_high,
    input  logic [W-1:0] act_first,
    input  logic         act_init_low,
    input  logic [W-1:0] ld_low,
    input  logic [W-1:0] ld_high,
    input  logic [W-1:0] ld_first,
    input  logic         ld_init_low,
    output wave_st_t     st,
    output logic [W-1:0] dwell,
    output logic         wave
);

    localparam logic [W-1:0] INF = '1;

    function automatic wave_st_t into_high(input logic [W-1:0] lo, input logic [W-1:0] hi);
        return (hi == '0 && lo != '0) ? ST_LOW : ST_HIGH;
    endfunction

    function automatic wave_st_t into_low(input logic [W-1:0] lo, input logic [W-1:0] hi);
        return (lo == '0 && hi != '0) ? ST_HIGH : ST_LOW;
    endfunction

    function automatic wave_st_t first_edge(input logic [W-1:0] lo, input logic [W-1:0] hi,
                                            input logic il);
        return il ? into_high(lo, hi) : into_low(lo, hi);
    endfunction

    wave_st_t     st_n;
    logic [W-1:0] dw_n;
    logic [W-1:0] dw_inc;

    always_comb begin
        dw_inc = (dwell == INF) ? INF : dwell + W'(1);
        st_n   = st;
        dw_n   = dwell;
        if (tick) begin
            unique case (st)
                ST_WAIT: begin
                    if (act_first != INF && cnt_nxt == act_first) begin
                        st_n = first_edge(act_low, act_high, act_init_low);
                        dw_n = '0;
                    end
                end
                ST_HIGH: begin
                    if (act_high != INF && dw_inc >= act_high) begin
                        st_n = into_low(act_low, act_high);
                        dw_n = '0;
                    end else begin
                        dw_n = dw_inc;
                    end
                end
                ST_LOW: begin
                    if (act_low != INF && dw_inc >= act_low) begin
                        st_n = into_high(act_low, act_high);
                        dw_n = '0;
                    end else begin
                        dw_n = dw_inc;
                    end
                end
                default: begin
                    st_n = ST_WAIT;
                    dw_n = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st    <= (ld_first == '0) ? first_edge(ld_low, ld_high, ld_init_low) : ST_WAIT;
            dwell <= '0;
        end else begin
            st    <= st_n;
            dwell <= dw_n;
        end
    end

    // outputs
    always_comb begin
        unique case (st)
            ST_HIGH: wave = 1'b1;
            ST_LOW:  wave = 1'b0;
            default: wave = !act_init_low;
        endcase
    end

endmodule

// File: rtl/clkwave_gen.sv
module clkwave_gen
    import clkwave_pkg::*;
#(
    parameter int W            = 16,
    parameter int DEF_LOW      = 4,
    parameter int DEF_HIGH     = 4,
    parameter int DEF_FIRST    = 2,
    parameter int DEF_INIT_LOW = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_data,
    input  logic         step_lvl,
    input  logic         step_valid,
    output logic         wave_out,
    output logic         wave_known
);

    logic [W-1:0] act_low, act_high, act_first;
    logic         act_init_low;
    logic [W-1:0] ld_low, ld_high, ld_first;
    logic         ld_init_low;
    logic         tick;
    logic [W-1:0] tick_cnt, tick_cnt_nxt;
    wave_st_t     st;
    logic [W-1:0] dwell;

    clkwave_cfg #(
        .W(W), .DEF_LOW(DEF_LOW), .DEF_HIGH(DEF_HIGH),
        .DEF_FIRST(DEF_FIRST), .DEF_INIT_LOW(DEF_INIT_LOW)
    ) u_cfg (
        .clk(clk), .rst(rst), .restart(restart),
        .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
        .act_low(act_low), .act_high(act_high), .act_first(act_first),
        .act_init_low(act_init_low),
        .ld_low(ld_low), .ld_high(ld_high), .ld_first(ld_first),
        .ld_init_low(ld_init_low)
    );

    clkwave_tick #(.W(W)) u_tick (
        .clk(clk), .rst(rst), .restart(restart),
        .lvl(step_lvl), .vld(step_valid),
        .tick(tick), .known(wave_known),
        .cnt(tick_cnt), .cnt_nxt(tick_cnt_nxt)
    );

    clkwave_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst(rst), .restart(restart),
        .tick(tick), .cnt_nxt(tick_cnt_nxt),
        .act_low(act_low), .act_high(act_high), .act_first(act_first),
        .act_init_low(act_init_low),
        .ld_low(ld_low), .ld_high(ld_high), .ld_first(ld_first),
        .ld_init_low(ld_init_low),
        .st(st), .dwell(dwell), .wave(wave_out)
    );

endmodule

// File: rtl/clkwave_chk.sv
module clkwave_chk
    import clkwave_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         restart,
    input logic         step_valid,
    input logic         tick,
    input logic         wave_out,
    input logic         wave_known,
    input logic [W-1:0] act_low,
    input logic [W-1:0] act_high,
    input logic [W-1:0] act_first,
    input logic         act_init_low,
    input wave_st_t     st,
    input logic [W-1:0] dwell,
    input logic [W-1:0] tick_cnt
);

    localparam logic [W-1:0] INF = '1;

    AST_TICK_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(wave_out)); // R1

    AST_UNKNOWN_FLAG: assert property (@(posedge clk) disable iff (rst)
        !step_valid |=> !wave_known); // R2

    AST_DWELL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HIGH && act_high != INF && act_high != '0) |-> dwell < act_high); // R4

    AST_DWELL_LOW: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOW && act_low != INF && act_low != '0) |-> dwell < act_low); // R5

    AST_STAGED_CFG: assert property (@(posedge clk) disable iff (rst)
        !restart |=> ($stable(act_low) && $stable(act_high) &&
                      $stable(act_first) && $stable(act_init_low))); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        !restart |=> tick_cnt >= $past(tick_cnt)); // R10

endmodule

bind clkwave_gen clkwave_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .restart(restart), .step_valid(step_valid),
    .tick(tick), .wave_out(wave_out), .wave_known(wave_known),
    .act_low(act_low), .act_high(act_high), .act_first(act_first),
    .act_init_low(act_init_low), .st(st), .dwell(dwell), .tick_cnt(tick_cnt)
);

// File: tb/tb_clkwave_gen.sv
module tb_clkwave_gen;

    localparam int W = 8;
    localparam longint BIG = 64'd1 << 40;
    localparam int CMAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         restart = 1'b0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = 2'd0;
    logic [W-1:0] cfg_data = '0;
    logic         step_lvl = 1'b0;
    logic         step_valid = 1'b1;
    logic         wave_out;
    logic         wave_known;

    always #5 clk = ~clk;

    clkwave_gen #(
        .W(W), .DEF_LOW(4), .DEF_HIGH(3), .DEF_FIRST(2), .DEF_INIT_LOW(1)
    ) dut (
        .clk(clk), .rst(rst), .restart(restart), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .step_lvl(step_lvl),
        .step_valid(step_valid), .wave_out(wave_out), .wave_known(wave_known)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int sL = 4, sH = 3, sF = 2, sI = 1;
    int aL = 4, aH = 3, aF = 2, aI = 1;
    int cnt = 0;
    int prv = 0;
    int mknown = 1;
    logic cur = 1'b0;

    function automatic longint expand(input int v);
        return (v == CMAX) ? BIG : longint'(v);
    endfunction

    function automatic int model_wave();
        longint L = expand(aL);
        longint H = expand(aH);
        longint F = expand(aF);
        longint c = longint'(cnt);
        longint t0;
        longint nrm;
        if (c < F) return (aI != 0) ? 0 : 1;
        t0  = (aI != 0) ? F + H : F;
        nrm = (c - t0 + H + L) % (H + L);
        return (nrm < L) ? 0 : 1;
    endfunction

    task automatic stage(input logic [1:0] s, input int d);
        case (s)
            2'd0: sL = d;
            2'd1: sH = d;
            2'd2: sF = d;
            default: sI = d & 1;
        endcase
    endtask

    task automatic check(input string tag);
        int ew = model_wave();
        checks++;
        if (wave_out !== ew[0] || wave_known !== mknown[0]) begin
            errors++;
            $display("FAIL %s: wave_out=%b wave_known=%b expected %0d %0d (ticks %0d)",
                     tag, wave_out, wave_known, ew, mknown, cnt);
        end
    endtask

    // one clock: drive at negedge, update model after posedge, compare at next negedge
    task automatic cyc(input logic lvl, input logic vld, input logic rs, input logic we,
                       input logic [1:0] sel, input int d, input string tag);
        step_lvl   = lvl;
        step_valid = vld;
        restart    = rs;
        cfg_we     = we;
        cfg_sel    = sel;
        cfg_data   = W'(d);
        @(posedge clk);
        if (we) stage(sel, d);
        if (rs) begin
            aL = sL; aH = sH; aF = sF; aI = sI;
            cnt = 0; prv = 0;
        end else if (vld && int'(lvl) != prv) begin
            if (cnt < CMAX) cnt++;
            prv = int'(lvl);
        end
        mknown = int'(vld);
        @(negedge clk);
        check(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            cur = !cur;
            cyc(cur, 1'b1, 1'b0, 1'b0, 2'd0, 0, tag);
        end
    endtask

    task automatic wr(input logic [1:0] s, input int d, input string tag);
        cyc(cur, 1'b1, 1'b0, 1'b1, s, d, tag);
    endtask

    task automatic rsrt(input string tag);
        cyc(cur, 1'b1, 1'b1, 1'b0, 2'd0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R8 reset defaults");
        ticks(2, "R3");
        ticks(20, "R4");

        // staged writes without restart keep the old waveform
        wr(2'd0, 3, "R8");
        wr(2'd1, 2, "R8");
        wr(2'd2, 5, "R8");
        wr(2'd3, 0, "R8");
        ticks(8, "R8");
        rsrt("R9");
        ticks(3, "R3");
        ticks(20, "R5");

        // unknown time-step level
        for (int i = 0; i < 6; i++) cyc(!cur, 1'b0, 1'b0, 1'b0, 2'd0, 0, "R2");
        ticks(1, "R2");
        for (int i = 0; i < 4; i++) cyc(cur, 1'b1, 1'b0, 1'b0, 2'd0, 0, "R1");

        // restart, write and tick in one cycle
        cur = !cur;
        cyc(cur, 1'b1, 1'b1, 1'b1, 2'd2, 1, "R9 same cycle");
        ticks(8, "R9");

        // infinite durations and saturation
        wr(2'd3, 1, "R6");
        wr(2'd1, CMAX, "R6");
        wr(2'd2, 1, "R6");
        rsrt("R6");
        ticks(300, "R10");
        wr(2'd1, 2, "R6");
        wr(2'd0, CMAX, "R6");
        rsrt("R6");
        ticks(300, "R10");
        wr(2'd2, CMAX, "R6");
        rsrt("R6");
        ticks(40, "R6");

        // zero durations and zero first edge
        wr(2'd2, 0, "R7");
        wr(2'd0, 0, "R7");
        wr(2'd1, 3, "R7");
        wr(2'd3, 0, "R7");
        rsrt("R7");
        ticks(10, "R7");
        wr(2'd0, 2, "R7");
        wr(2'd1, 0, "R7");
        wr(2'd3, 1, "R7");
        rsrt("R7");
        ticks(10, "R7");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule